// File: doc/BRIEF.md
# Serial Shift Engine with Movable Capture Point

This block moves one byte at a time over a synchronous four-wire style serial link. A parallel write loads a byte into the transmit shifter and starts a transfer. Eight bits then leave on the serial output, most significant bit first. At the same time eight bits are collected from the serial input into a receive buffer. A buffer-full flag signals that a received byte is waiting, and reading the buffer clears that flag.

As master, the block drives the serial clock from a programmable divider of the system clock. Three mode inputs control the link. The first sets the idle level of the serial clock. The second chooses which serial-clock transition launches each output bit. The third moves input capture from the middle of each bit to its end, and this choice does not depend on the launch edge. As slave, the block follows an external serial clock. A write arms the transfer. Capture always happens mid-bit, whatever the capture-point input says.

The divider and all mode inputs are taken in when a transfer starts. They hold until it completes. A write that arrives during a transfer is dropped and sets a collision flag.

Top module: `sser_engine`

## Requirements
- R1: After reset, busy, buf_full, wr_coll, sck_o, sdo and rd_data are all 0.
- R2: A master transfer sends wr_data on sdo most significant bit first. Each of the 8 bits stays on sdo for one full serial-clock period.
- R3: With cfg_late_smp=0 in master mode, each received bit is the value of sdi at the serial-clock edge in the middle of that bit.
- R4: With cfg_late_smp=1 in master mode, each received bit is the value of sdi just before the launch edge that ends that bit.
- R5: While idle, sck_o equals cfg_idle_hi. During a transfer, the launch edge is falling when cfg_launch_fall=1 and rising when it is 0, at either idle level. The first half of each bit therefore sits at level ~cfg_launch_fall.
- R6: The serial-clock period is 2*(cfg_div+1) system clocks, and a transfer lasts 16*(cfg_div+1) clocks. Changes to cfg_div, cfg_idle_hi or cfg_late_smp during a transfer have no effect on it.
- R7: In slave mode (cfg_slave=1), a write arms the transfer. Bits are captured on the non-launch edge of sck_i and launched on the other edge, and cfg_late_smp is ignored. Edges on sck_i while not armed change no state.
- R8: buf_full goes to 1 when a transfer completes, and rd_data then holds the received byte. A pulse on rd_stb clears buf_full and leaves rd_data unchanged.
- R9: A write while busy=1 is ignored and sets wr_coll to 1. The next accepted write clears wr_coll.
- R10: busy is 1 from the clock after an accepted write until the transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle_hi | input | 1 | Idle level of the serial clock |
| cfg_launch_fall | input | 1 | 1: launch on falling edge, 0: on rising edge |
| cfg_late_smp | input | 1 | Master capture point: 1 end of bit, 0 mid-bit |
| cfg_slave | input | 1 | 1 selects slave mode |
| cfg_div | input | DIV_W | Half-period divider value |
| wr_stb | input | 1 | Write strobe, starts a transfer |
| wr_data | input | DATA_W | Byte to transmit |
| rd_stb | input | 1 | Read strobe, clears buf_full |
| rd_data | output | DATA_W | Receive buffer |
| buf_full | output | 1 | Received byte waiting |
| wr_coll | output | 1 | Write arrived during a transfer |
| busy | output | 1 | Transfer in progress |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the engine with DATA_W=8, DIV_W=4 and SYNC_STAGES=2. The narrow divider puts its largest value, 15 (a 32-clock serial period), within reach of a short run, and a divider of 0 tests one-clock half periods. The bench's serial-side model changes sdi between the two halves of every bit, so the mid-bit and end-of-bit capture points return different bytes. The same model shows that slave mode ignores the late-capture request.

// File: rtl/sser_pkg.sv
package sser_pkg;

  // Transfer configuration, frozen while a transfer runs
  typedef struct packed {
    logic idle_hi;      // serial clock level between transfers
    logic launch_fall;  // output bits change on falling edge when set
    logic late;         // capture at end of bit (master only)
    logic slave;        // follow external serial clock
  } sser_mode_t;

endpackage

// File: rtl/sser_clkgen.sv
module sser_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             half,
  output logic             mid_evt,
  output logic             end_evt
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             half_q, half_d;

  always_comb begin
    cnt_d   = cnt_q;
    div_d   = div_q;
    half_d  = half_q;
    mid_evt = 1'b0;
    end_evt = 1'b0;
    if (start) begin
      div_d  = div_in;
      cnt_d  = '0;
      half_d = 1'b0;
    end else if (run) begin
      if (cnt_q == div_q) begin
        cnt_d   = '0;
        half_d  = ~half_q;
        mid_evt = ~half_q;
        end_evt = half_q;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      div_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      half_q <= half_d;
    end
  end

  assign half = half_q;

  // R6: divider held for the whole transfer
  a_r6_div_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && !start) |=> (div_q == $past(div_q)));

endmodule

// File: rtl/sser_sync_edge.sv
module sser_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic sck_in,
  input  logic sdi_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_sync
);

  logic [STAGES-1:0] sck_q, sdi_q;
  logic              sck_prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q      <= '0;
      sdi_q      <= '0;
      sck_prev_q <= 1'b0;
    end else begin
      sck_q      <= {sck_q[STAGES-2:0], sck_in};
      sdi_q      <= {sdi_q[STAGES-2:0], sdi_in};
      sck_prev_q <= sck_q[STAGES-1];
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_prev_q;
  assign sck_fall = ~sck_q[STAGES-1] & sck_prev_q;
  assign sdi_sync = sdi_q[STAGES-1];

endmodule

// File: rtl/sser_shifter.sv
module sser_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  input  logic              cap,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rx_cur,
  output logic [DATA_W-1:0] rx_next
);

  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  assign rx_next = {rx_q[DATA_W-2:0], sdi};

  always_comb begin
    tx_d = tx_q;
    if (load)       tx_d = load_data;
    else if (shift) tx_d = {tx_q[DATA_W-2:0], 1'b0};
    rx_d = cap ? rx_next : rx_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign sdo    = tx_q[DATA_W-1];
  assign rx_cur = rx_q;

endmodule

// File: rtl/sser_engine.sv
module sser_engine
  import sser_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_idle_hi,
  input  logic              cfg_launch_fall,
  input  logic              cfg_late_smp,
  input  logic              cfg_slave,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic              wr_coll,
  output logic              busy,
  output logic              sck_o,
  input  logic              sck_i,
  output logic              sdo,
  input  logic              sdi
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  // Reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_ni   <= rst_s1_q;
    end
  end

  sser_mode_t        mode_q, mode_d, cfg_now;
  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic              bf_q, bf_d;
  logic              wcol_q, wcol_d;
  logic [DATA_W-1:0] rxbuf_q, rxbuf_d;

  logic accept, collide, master_run, slave_run;
  logic half, mid_evt, end_evt;
  logic s_rise, s_fall, sdi_sync, sdi_use;
  logic s_cap_edge, s_launch_edge;
  logic cap_evt, cnt_evt, sh_evt, fin;
  logic [DATA_W-1:0] rx_cur, rx_next;

  assign accept     = wr_stb & ~busy_q;
  assign collide    = wr_stb & busy_q;
  assign master_run = busy_q & ~mode_q.slave;
  assign slave_run  = busy_q & mode_q.slave;

  // Configuration follows the inputs while idle; slave forces mid-bit capture
  always_comb begin
    cfg_now.idle_hi     = cfg_idle_hi;
    cfg_now.launch_fall = cfg_launch_fall;
    cfg_now.late        = cfg_late_smp & ~cfg_slave;
    cfg_now.slave       = cfg_slave;
    mode_d              = busy_q ? mode_q : cfg_now;
  end

  sser_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .start   (accept),
    .run     (master_run),
    .div_in  (cfg_div),
    .half    (half),
    .mid_evt (mid_evt),
    .end_evt (end_evt)
  );

  sser_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .sck_in   (sck_i),
    .sdi_in   (sdi),
    .sck_rise (s_rise),
    .sck_fall (s_fall),
    .sdi_sync (sdi_sync)
  );

  assign s_cap_edge    = mode_q.launch_fall ? s_rise : s_fall;
  assign s_launch_edge = mode_q.launch_fall ? s_fall : s_rise;
  assign sdi_use       = mode_q.slave ? sdi_sync : sdi;

  always_comb begin
    if (master_run) begin
      cap_evt = mode_q.late ? end_evt : mid_evt;
      cnt_evt = end_evt;
      sh_evt  = end_evt;
    end else begin
      cap_evt = slave_run & s_cap_edge;
      cnt_evt = slave_run & s_cap_edge;
      sh_evt  = slave_run & s_launch_edge & (bit_q != '0);
    end
    fin = cnt_evt & (bit_q == LAST_BIT);
  end

  sser_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .load      (accept),
    .load_data (wr_data),
    .shift     (sh_evt),
    .cap       (cap_evt),
    .sdi       (sdi_use),
    .sdo       (sdo),
    .rx_cur    (rx_cur),
    .rx_next   (rx_next)
  );

  always_comb begin
    busy_d  = busy_q;
    bit_d   = bit_q;
    bf_d    = bf_q;
    wcol_d  = wcol_q;
    rxbuf_d = rxbuf_q;
    if (accept) begin
      busy_d = 1'b1;
      bit_d  = '0;
      wcol_d = 1'b0;
    end else if (fin) begin
      busy_d = 1'b0;
    end else if (cnt_evt) begin
      bit_d = bit_q + CNT_W'(1);
    end
    if (collide) wcol_d = 1'b1;
    if (fin) begin
      rxbuf_d = cap_evt ? rx_next : rx_cur;
      bf_d    = 1'b1;
    end else if (rd_stb) begin
      bf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      busy_q  <= 1'b0;
      bit_q   <= '0;
      bf_q    <= 1'b0;
      wcol_q  <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      mode_q  <= mode_d;
      busy_q  <= busy_d;
      bit_q   <= bit_d;
      bf_q    <= bf_d;
      wcol_q  <= wcol_d;
      rxbuf_q <= rxbuf_d;
    end
  end

  assign sck_o    = master_run ? (half ? mode_q.launch_fall : ~mode_q.launch_fall)
                               : mode_q.idle_hi;
  assign rd_data  = rxbuf_q;
  assign buf_full = bf_q;
  assign wr_coll  = wcol_q;
  assign busy     = busy_q;

  // R5: a new output bit appears only with a launch-edge transition of sck_o
  a_r5_launch_edge: assert property (@(posedge clk) disable iff (!rst_ni)
    (master_run && $past(master_run) && (sdo != $past(sdo)))
      |-> ((sck_o != $past(sck_o)) && (sck_o == ~mode_q.launch_fall)));

  // R3 and R4: master capture always coincides with a serial clock transition
  a_r4_cap_on_sck_edge: assert property (@(posedge clk) disable iff (!rst_ni)
    (master_run && cap_evt && !fin) |=> (sck_o != $past(sck_o)));

  a_r8_bf_set: assert property (@(posedge clk) disable iff (!rst_ni)
    fin |=> buf_full);

  a_r8_rd_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_stb && !fin) |=> !buf_full);

  a_r9_coll_flag: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_stb && busy_q) |=> wr_coll);

endmodule

// File: tb/sser_engine_test.sv
module sser_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;

  logic       clk;
  logic       rst_n;
  logic       cfg_idle_hi, cfg_launch_fall, cfg_late_smp, cfg_slave;
  logic [3:0] cfg_div;
  logic       wr_stb, rd_stb;
  logic [7:0] wr_data, rd_data;
  logic       buf_full, wr_coll, busy, sck_o, sck_i, sdo, sdi;

  int checks = 0;
  int fails  = 0;

  sser_engine #(.DATA_W(8), .DIV_W(4), .SYNC_STAGES(2)) uut (
    .clk (clk), .rst_n (rst_n),
    .cfg_idle_hi (cfg_idle_hi), .cfg_launch_fall (cfg_launch_fall),
    .cfg_late_smp (cfg_late_smp), .cfg_slave (cfg_slave), .cfg_div (cfg_div),
    .wr_stb (wr_stb), .wr_data (wr_data), .rd_stb (rd_stb), .rd_data (rd_data),
    .buf_full (buf_full), .wr_coll (wr_coll), .busy (busy),
    .sck_o (sck_o), .sck_i (sck_i), .sdo (sdo), .sdi (sdi)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // {idle_hi, launch_fall, late, div[3:0], tx, mid-half data, late-half data}
  localparam logic [30:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 4'd1,  8'hA5, 8'h3C, 8'hC3},
    {1'b0, 1'b1, 1'b0, 4'd0,  8'h5A, 8'h96, 8'h69},
    {1'b1, 1'b0, 1'b0, 4'd2,  8'h81, 8'hF0, 8'h0F},
    {1'b1, 1'b1, 1'b0, 4'd3,  8'h7E, 8'h0F, 8'hF0},
    {1'b0, 1'b0, 1'b1, 4'd1,  8'hC3, 8'h12, 8'hED},
    {1'b0, 1'b1, 1'b1, 4'd15, 8'h3C, 8'hAA, 8'h55},
    {1'b1, 1'b0, 1'b1, 4'd0,  8'hFF, 8'h00, 8'hFF},
    {1'b1, 1'b1, 1'b1, 4'd4,  8'h01, 8'h80, 8'h7F}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] exp_data);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk(buf_full == 1'b0, "R8", "buf_full after read", buf_full, 0);
    chk(rd_data == exp_data, "R8", "rd_data kept after read", rd_data, exp_data);
  endtask

  task automatic run_master(input logic ih, input logic fl, input logic lt,
                            input logic [3:0] dv, input logic [7:0] tx,
                            input logic [7:0] a, input logic [7:0] b,
                            input int coll_at, input int mess_at);
    int cnt, t, last_mid;
    logic prev;
    logic [7:0] got, exp_rx;
    bit per_ok;
    @(negedge clk);
    cfg_idle_hi = ih; cfg_launch_fall = fl; cfg_late_smp = lt;
    cfg_slave = 1'b0; cfg_div = dv;
    repeat (2) @(negedge clk);
    chk(sck_o == ih, "R5", "idle level before start", sck_o, ih);
    wr_data = tx; wr_stb = 1'b1; sdi = a[7];
    @(negedge clk); wr_stb = 1'b0;
    chk(busy == 1'b1, "R10", "busy after write", busy, 1);
    chk(sck_o == ~fl, "R5", "first half level", sck_o, ~fl);
    cnt = 0; t = 0; last_mid = -1; prev = sck_o; got = '0; per_ok = 1'b1;
    while (busy && t < 4000) begin
      if (t == coll_at) begin wr_stb = 1'b1; wr_data = ~tx; end
      else wr_stb = 1'b0;
      if (mess_at >= 0 && t == mess_at) begin
        cfg_div = ~dv; cfg_late_smp = ~lt; cfg_idle_hi = ~ih;
      end
      if (mess_at >= 0 && t == mess_at + 1) begin
        cfg_div = dv; cfg_late_smp = lt; cfg_idle_hi = ih;
      end
      if (sck_o != prev && sck_o == fl) begin
        cnt++;
        got = {got[6:0], sdo};
        if (last_mid >= 0 && (t - last_mid) != 2 * (int'(dv) + 1)) per_ok = 1'b0;
        last_mid = t;
      end
      prev = sck_o;
      if (sck_o == fl && cnt > 0) sdi = b[8 - cnt];
      else if (cnt < 8) sdi = a[7 - cnt];
      @(negedge clk); t++;
    end
    wr_stb = 1'b0;
    exp_rx = lt ? b : a;
    chk(rd_data == exp_rx, lt ? "R4" : "R3", "received byte", rd_data, exp_rx);
    chk(got == tx, "R2", "bits on sdo", got, tx);
    chk(t == 16 * (int'(dv) + 1), "R6", "transfer length", t, 16 * (int'(dv) + 1));
    chk(per_ok && cnt == 8, "R6", "serial period and edge count", cnt, 8);
    chk(buf_full == 1'b1, "R8", "buf_full at completion", buf_full, 1);
    chk(sck_o == ih, "R5", "idle level after end", sck_o, ih);
  endtask

  task automatic run_slave(input logic ih, input logic fl, input logic lt,
                           input logic [7:0] tx, input logic [7:0] a,
                           input logic [7:0] b);
    logic [7:0] got;
    got = '0;
    @(negedge clk);
    cfg_idle_hi = ih; cfg_launch_fall = fl; cfg_late_smp = lt; cfg_slave = 1'b1;
    sck_i = ih;
    @(negedge clk);
    wr_data = tx; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    chk(busy == 1'b1, "R7", "slave armed by write", busy, 1);
    repeat (4) @(negedge clk);
    sck_i = ~fl; sdi = a[7];
    repeat (H) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      got = {got[6:0], sdo};
      sck_i = fl;
      repeat (4) @(negedge clk);
      sdi = b[7 - i];
      repeat (H - 4) @(negedge clk);
      sck_i = ~fl;
      sdi = (i < 7) ? a[6 - i] : 1'b0;
      repeat (H) @(negedge clk);
    end
    sck_i = ih;
    repeat (6) @(negedge clk);
    chk(rd_data == a, "R7", "slave mid-bit capture", rd_data, a);
    chk(got == tx, "R7", "slave bits on sdo", got, tx);
    chk(buf_full == 1'b1, "R8", "slave buf_full", buf_full, 1);
    chk(busy == 1'b0, "R10", "slave busy cleared", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R10 actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_idle_hi = 1'b0; cfg_launch_fall = 1'b0; cfg_late_smp = 1'b0;
    cfg_slave = 1'b0; cfg_div = '0;
    wr_stb = 1'b0; rd_stb = 1'b0; wr_data = '0; sck_i = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(buf_full == 1'b0, "R1", "buf_full", buf_full, 0);
    chk(wr_coll == 1'b0, "R1", "wr_coll", wr_coll, 0);
    chk(sck_o == 1'b0, "R1", "sck_o", sck_o, 0);
    chk(sdo == 1'b0, "R1", "sdo", sdo, 0);
    chk(rd_data == 8'h00, "R1", "rd_data", rd_data, 0);

    // Vector table: every polarity, edge and capture point combination
    for (int i = 0; i < 8; i++) begin
      logic [30:0] v;
      v = VEC[i];
      run_master(v[30], v[29], v[28], v[27:24], v[23:16], v[15:8], v[7:0], -1, -1);
      do_read(v[28] ? v[7:0] : v[15:8]);
    end

    // R9: write during a transfer is dropped and flagged
    run_master(1'b0, 1'b1, 1'b0, 4'd2, 8'h6C, 8'h33, 8'hCC, 10, -1);
    chk(wr_coll == 1'b1, "R9", "collision flag set", wr_coll, 1);
    do_read(8'h33);
    run_master(1'b0, 1'b0, 1'b0, 4'd0, 8'h18, 8'hE7, 8'h18, -1, -1);
    chk(wr_coll == 1'b0, "R9", "collision flag cleared by accepted write", wr_coll, 0);
    do_read(8'hE7);

    // R6: configuration changes mid-transfer are ignored
    run_master(1'b1, 1'b0, 1'b1, 4'd3, 8'h96, 8'h4B, 8'hB4, -1, 9);
    do_read(8'hB4);

    // R7: slave ignores late capture request
    run_slave(1'b0, 1'b1, 1'b1, 8'hC5, 8'h5C, 8'hA3);
    do_read(8'h5C);

    // R7: unarmed serial clock edges change nothing
    @(negedge clk); cfg_slave = 1'b1; cfg_launch_fall = 1'b0;
    for (int k = 0; k < 16; k++) begin
      sck_i = ~sck_i; sdi = ~sdi;
      repeat (H) @(negedge clk);
    end
    chk(busy == 1'b0, "R7", "unarmed edges busy", busy, 0);
    chk(buf_full == 1'b0, "R7", "unarmed edges buf_full", buf_full, 0);
    chk(rd_data == 8'h5C, "R7", "unarmed edges rd_data", rd_data, 8'h5C);
    run_slave(1'b1, 1'b0, 1'b0, 8'h3A, 8'hD2, 8'h2D);
    do_read(8'hD2);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule